// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen interrupt positions for a CPU. The lower eight are hardware lines. Each line can be sensed either as a level or as a latched edge, and each line has its own polarity. The upper eight positions are raised by software writes. The block holds pending, mask and in-service state and picks one winner using a circular priority order. It drives a single interrupt request and presents an 8-bit vector that names the winner.

The CPU accepts the winner with a one-cycle acknowledge pulse, which marks that position in service. It later ends the handler with a one-cycle end-of-interrupt pulse. One register names the position with first priority, and the positions after it follow in circular order. In rotate mode, the acknowledged position moves to last place automatically. Configuration uses a small register bus: writes are synchronous, and reads are combinational from the address.

Top module: `vic16_ctrl`

## Requirements
- R1: After reset, the following are all zero: irq_o, mask, sense, polarity, in-service, pending and the first-priority index.
- R2: A level-sensed line (sense bit 0, written at address 1) is pending exactly while its synchronized input equals the active level. Polarity bit 0 (address 2) means active high and 1 means active low. Pending is not held after the input drops.
- R3: An edge-sensed line (sense bit 1) latches pending on a transition. Polarity 0 selects rising edges and polarity 1 selects falling edges. The latch holds until the position is acknowledged.
- R4: Writing address 4 sets the pending bits of positions 8 to 15 wherever the matching bits 15:8 of the written data are 1. Zero bits leave those positions unchanged. Address 4 reads back all sixteen pending bits.
- R5: A position whose mask bit is 1 (address 3) never wins. Its pending bit still reads back.
- R6: A position's rank is (position − first) mod 16, where first is written at address 5. The unmasked pending position with the lowest rank wins.
- R7: vec_o equals {base[3:0], winner index[3:0]}, where base is written at address 0 bits 3:0.
- R8: An acknowledge while irq_o is high sets the winner's in-service bit (read at address 7) and clears its latched pending bit. An acknowledge while irq_o is low has no effect.
- R9: A pending position wins only if its rank is strictly lower than the rank of every in-service position.
- R10: End-of-interrupt clears the in-service bit of the lowest-rank in-service position. It has no effect when no position is in service.
- R11: When address 6 bit 0 is 1 (rotate mode), an acknowledge sets first to (winner + 1) mod 16. When that bit is 0 (fixed mode), first changes only through writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_irq_i | input | 8 | Asynchronous hardware interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector of the current winner |
| ack_i | input | 1 | Acknowledge pulse, one cycle |
| eoi_i | input | 1 | End-of-interrupt pulse, one cycle |

## Verification
Register writes, acknowledges and end-of-interrupt pulses take effect at the next clock edge. irq_o and vec_o follow combinationally from that edge. A level input reaches pending after two edges through the synchronizer, and an edge input reaches pending after three. Every check waits four cycles after changing a hardware line, and at least one cycle after any bus or handshake pulse. Outputs are sampled on the falling clock edge, so each result is read only after the last register on its path has updated.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int IDX_W = 4;
  localparam int NPOS  = 1 << IDX_W;

  typedef enum logic [2:0] {
    A_BASE  = 3'd0,
    A_SENSE = 3'd1,
    A_POLAR = 3'd2,
    A_MASK  = 3'd3,
    A_PEND  = 3'd4,
    A_FIRST = 3'd5,
    A_MODE  = 3'd6,
    A_INSV  = 3'd7
  } reg_addr_e;

  // circular distance from the first-priority position
  function automatic logic [IDX_W-1:0] rank_of(input logic [IDX_W-1:0] pos,
                                               input logic [IDX_W-1:0] first);
    return pos - first;
  endfunction

  function automatic logic [2*IDX_W-1:0] make_vec(input logic [IDX_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return {base, idx};
  endfunction
endpackage

// File: rtl/vic_sense.sv
module vic_sense #(
  parameter int NHW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NHW-1:0] hw_i,
  input  logic [NHW-1:0] edge_mode,
  input  logic [NHW-1:0] polar,
  input  logic [NHW-1:0] clr,
  output logic [NHW-1:0] pend
);
  for (genvar g = 0; g < NHW; g++) begin : g_line
    logic s1, s2, prv, latch;
    logic q_now, q_prev, edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; prv <= 1'b0;
      end else begin
        s1 <= hw_i[g]; s2 <= s1; prv <= s2;
      end
    end

    assign q_now    = s2 ^ polar[g];
    assign q_prev   = prv ^ polar[g];
    assign edge_hit = q_now & ~q_prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      latch <= 1'b0;
      else if (!edge_mode[g])          latch <= 1'b0;
      else if (edge_hit)               latch <= 1'b1;
      else if (clr[g])                 latch <= 1'b0;
    end

    assign pend[g] = edge_mode[g] ? latch : q_now;

    // R3: a latched edge is held until cleared
    a_r3_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[g] && latch && !clr[g]) |=> (latch || !edge_mode[g]));
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N  = NPOS,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  insv,
  input  logic [IW-1:0] first,
  output logic          win_valid,
  output logic [IW-1:0] win_idx,
  output logic          isv_any,
  output logic [IW-1:0] isv_idx
);
  logic [IW:0] win_k, isv_k;

  always_comb begin
    logic [IW-1:0] p;
    win_k = (IW+1)'(N);
    isv_k = (IW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      p = first + IW'(k);
      if (req[p])  win_k = (IW+1)'(k);
      if (insv[p]) isv_k = (IW+1)'(k);
    end
  end

  assign win_valid = win_k < isv_k;
  assign isv_any   = isv_k != (IW+1)'(N);
  assign win_idx   = first + win_k[IW-1:0];
  assign isv_idx   = first + isv_k[IW-1:0];

  // R9: a winner is never already in service and outranks all in service
  a_r9_win_not_insv: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !insv[win_idx]);
  a_r9_win_outranks: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && isv_any) |-> (rank_of(win_idx, first) < rank_of(isv_idx, first)));
endmodule

// File: rtl/vic16_ctrl.sv
module vic16_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_HW = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int NSW   = NPOS - NUM_HW,
  localparam int VEC_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              ack_i,
  input  logic              eoi_i
);
  logic [IDX_W-1:0]  base_q, first_q;
  logic [NUM_HW-1:0] sense_q, polar_q, hw_pend;
  logic [NPOS-1:0]   mask_q, insv_q, pend_all, ack_hot;
  logic [NSW-1:0]    swp_q;
  logic              rot_q;

  logic              win_valid, isv_any, ack_fire, wr_first;
  logic [IDX_W-1:0]  win_idx, isv_idx;

  assign ack_fire = ack_i & win_valid;
  assign ack_hot  = ack_fire ? (NPOS'(1) << win_idx) : '0;
  assign wr_first = wr_en_i && (addr_i == A_FIRST);

  vic_sense #(.NHW(NUM_HW)) u_sense (
    .clk(clk), .rst_n(rst_n), .hw_i(hw_irq_i), .edge_mode(sense_q),
    .polar(polar_q), .clr(ack_hot[NUM_HW-1:0]), .pend(hw_pend)
  );

  assign pend_all = {swp_q, hw_pend};

  vic_arbiter #(.N(NPOS), .IW(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(pend_all & ~mask_q), .insv(insv_q),
    .first(first_q), .win_valid(win_valid), .win_idx(win_idx),
    .isv_any(isv_any), .isv_idx(isv_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; sense_q <= '0; polar_q <= '0; mask_q <= '0; rot_q <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_BASE:  base_q  <= wdata_i[IDX_W-1:0];
        A_SENSE: sense_q <= wdata_i[NUM_HW-1:0];
        A_POLAR: polar_q <= wdata_i[NUM_HW-1:0];
        A_MASK:  mask_q  <= wdata_i[NPOS-1:0];
        A_MODE:  rot_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swp_q <= '0;
    else swp_q <= (swp_q & ~ack_hot[NPOS-1:NUM_HW])
                | ((wr_en_i && addr_i == A_PEND) ? wdata_i[NPOS-1:NUM_HW] : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) insv_q <= '0;
    else insv_q <= (insv_q & ~((eoi_i && isv_any) ? (NPOS'(1) << isv_idx) : '0))
                 | ack_hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                first_q <= '0;
    else if (wr_first)         first_q <= wdata_i[IDX_W-1:0];
    else if (ack_fire && rot_q) first_q <= win_idx + IDX_W'(1);
  end

  always_comb begin
    case (addr_i)
      A_BASE:  rdata_o = DATA_W'(base_q);
      A_SENSE: rdata_o = DATA_W'(sense_q);
      A_POLAR: rdata_o = DATA_W'(polar_q);
      A_MASK:  rdata_o = DATA_W'(mask_q);
      A_PEND:  rdata_o = DATA_W'(pend_all);
      A_FIRST: rdata_o = DATA_W'(first_q);
      A_MODE:  rdata_o = DATA_W'(rot_q);
      default: rdata_o = DATA_W'(insv_q);
    endcase
  end

  assign irq_o = win_valid;
  assign vec_o = make_vec(base_q, win_idx);

  // R8: acknowledge marks the winner in service
  a_r8_ack_sets_insv: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> insv_q[$past(win_idx)]);
  // R8: acknowledge without a request changes nothing in service
  a_r8_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_i) |=> (insv_q == $past(insv_q)));
  // R10: end-of-interrupt retires the top in-service position
  a_r10_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && isv_any && !(ack_i && irq_o)) |=> !insv_q[$past(isv_idx)]);
  // R5: masked positions never win
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !mask_q[win_idx]);
  // R11: rotation and fixed hold of the first-priority index
  a_r11_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && rot_q && !wr_first) |=> (first_q == IDX_W'($past(win_idx) + 4'd1)));
  a_r11_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_q && !wr_first) |=> (first_q == $past(first_q)));
endmodule

// File: tb/vic16_ctrl_tb.sv
module vic16_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hw_irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  logic [7:0]  vec_o;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vic16_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .vec_o(vec_o), .ack_i(ack_i), .eoi_i(eoi_i)
  );

  // entry: first[3:0], hw[7:0], irq, vector[7:0]  (base 0xA, level, active high)
  localparam logic [20:0] TBL [9] = '{
    {4'd0, 8'h00, 1'b0, 8'h00},
    {4'd0, 8'h01, 1'b1, 8'hA0},
    {4'd0, 8'h06, 1'b1, 8'hA1},
    {4'd0, 8'hC0, 1'b1, 8'hA6},
    {4'd5, 8'h81, 1'b1, 8'hA7},
    {4'd1, 8'h81, 1'b1, 8'hA7},
    {4'd7, 8'h41, 1'b1, 8'hA0},
    {4'd3, 8'h0C, 1'b1, 8'hA3},
    {4'd6, 8'hFF, 1'b1, 8'hA6}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk); eoi_i = 1'b1;
    @(negedge clk); eoi_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic e_irq, input logic [7:0] e_vec);
    @(negedge clk);
    chk({tag, " irq"}, 16'(irq_o), 16'(e_irq));
    if (e_irq) chk({tag, " vec"}, 16'(vec_o), 16'(e_vec));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_out("R1 reset", 1'b0, 8'h00);
    rd(3'd3, r); chk("R1 mask", r, 16'h0000);
    rd(3'd1, r); chk("R1 sense", r, 16'h0000);
    rd(3'd2, r); chk("R1 polarity", r, 16'h0000);
    rd(3'd4, r); chk("R1 pending", r, 16'h0000);
    rd(3'd5, r); chk("R1 first", r, 16'h0000);
    rd(3'd7, r); chk("R1 insv", r, 16'h0000);

    wr(3'd0, 16'h000A);

    // table walk: R2 level sensing, R6 circular priority, R7 vector
    for (int i = 0; i < 9; i++) begin
      wr(3'd5, 16'(TBL[i][20:17]));
      @(negedge clk); hw_irq_i = TBL[i][16:9];
      settle();
      chk_out($sformatf("R6/R7 vector %0d", i), TBL[i][8], TBL[i][7:0]);
    end
    hw_irq_i = 8'h00; wr(3'd5, 16'h0000); settle();

    // R2 level not latched
    hw_irq_i = 8'h01; settle(); chk_out("R2 level on", 1'b1, 8'hA0);
    hw_irq_i = 8'h00; settle(); chk_out("R2 level off", 1'b0, 8'h00);
    // R2 active low polarity
    wr(3'd2, 16'h0010); settle(); chk_out("R2 active low", 1'b1, 8'hA4);
    wr(3'd2, 16'h0000); settle();

    // R5 mask
    hw_irq_i = 8'h05; settle();
    wr(3'd3, 16'h0001); chk_out("R5 masked skip", 1'b1, 8'hA2);
    rd(3'd4, r); chk("R5 masked still pending", r, 16'h0005);
    wr(3'd3, 16'h0005); chk_out("R5 all masked", 1'b0, 8'h00);
    wr(3'd3, 16'h0000); hw_irq_i = 8'h00; settle();

    // R3 rising edge latched
    wr(3'd1, 16'h0008);
    hw_irq_i = 8'h08; @(negedge clk); hw_irq_i = 8'h00; settle();
    rd(3'd4, r); chk("R3 rising latched", r, 16'h0008);
    chk_out("R3 edge request", 1'b1, 8'hA3);
    pulse_ack();
    rd(3'd4, r); chk("R3 cleared by ack", r, 16'h0000);
    rd(3'd7, r); chk("R8 insv set", r, 16'h0008);
    pulse_eoi();
    rd(3'd7, r); chk("R10 eoi clears", r, 16'h0000);

    // R3 falling edge
    hw_irq_i = 8'h20; settle();
    wr(3'd1, 16'h0028); wr(3'd2, 16'h0020); settle();
    rd(3'd4, r); chk("R3 no falling yet", r, 16'h0000);
    hw_irq_i = 8'h00; settle();
    rd(3'd4, r); chk("R3 falling latched", r, 16'h0020);
    chk_out("R3 falling request", 1'b1, 8'hA5);
    pulse_ack(); pulse_eoi();
    wr(3'd1, 16'h0000); wr(3'd2, 16'h0000); settle();

    // R4 software requests, R9 nesting
    wr(3'd4, 16'h1000);
    wr(3'd4, 16'h0000);
    rd(3'd4, r); chk("R4 software set", r, 16'h1000);
    chk_out("R4 software vector", 1'b1, 8'hAC);
    pulse_ack();
    wr(3'd4, 16'h8000);
    chk_out("R9 lower blocked", 1'b0, 8'h00);
    wr(3'd4, 16'h0200);
    chk_out("R9 higher nests", 1'b1, 8'hA9);
    pulse_ack();
    rd(3'd7, r); chk("R9 nested insv", r, 16'h1200);
    chk_out("R9 blocked by both", 1'b0, 8'h00);
    pulse_eoi();
    rd(3'd7, r); chk("R10 clears top first", r, 16'h1000);
    pulse_eoi();
    rd(3'd7, r); chk("R10 clears remaining", r, 16'h0000);
    chk_out("R9 unblocked", 1'b1, 8'hAF);
    pulse_ack(); pulse_eoi();

    // R8 idle acknowledge, R10 idle eoi
    chk_out("R8 idle", 1'b0, 8'h00);
    pulse_ack();
    rd(3'd7, r); chk("R8 idle ack no effect", r, 16'h0000);
    pulse_eoi();
    rd(3'd7, r); chk("R10 idle eoi no effect", r, 16'h0000);

    // R11 rotate mode
    wr(3'd6, 16'h0001);
    wr(3'd4, 16'h0600);
    chk_out("R11 rotate first win", 1'b1, 8'hA9);
    pulse_ack();
    rd(3'd5, r); chk("R11 first rotated", r, 16'h000A);
    chk_out("R11 rotated nest", 1'b1, 8'hAA);
    pulse_ack();
    rd(3'd5, r); chk("R11 first rotated again", r, 16'h000B);
    pulse_eoi();
    rd(3'd7, r); chk("R10 rotated order", r, 16'h0400);
    pulse_eoi();

    // R11 fixed mode
    wr(3'd6, 16'h0000); wr(3'd5, 16'h0002);
    wr(3'd4, 16'h0100);
    pulse_ack();
    rd(3'd5, r); chk("R11 fixed keeps first", r, 16'h0002);
    pulse_eoi();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule